// File: doc/BRIEF.md
# Rate-Limited Fan Speed Ramp Generator

This block produces the 8-bit code for a fan-speed DAC. Firmware writes a target speed into a register port. With ramping switched off, that target goes to the DAC code right away. With ramping switched on, an internal counter moves the DAC code toward the target by one count per ramp tick. The tick rate is selectable, which keeps audible fan-speed steps small. The ramp tick is derived on-chip from the system clock by a prescaler. Its clock-frequency parameter can be set to a small value for simulation.

The counter keeps tracking the target while ramping is off. Enabling the ramp therefore never makes the output jump. A new target written mid-ramp can turn the count around. A full-scale override input forces the code to all ones within the same cycle and bypasses the ramp. When the override is released, the output returns to whatever the counter holds.

Top module: `fan_ramp_gen`

## Requirements
- R1: An active-low reset sets the target, the counter and the prescaler to zero. While reset is held and no override is applied, `dac_code` reads 00h. Reset takes effect asynchronously.
- R2: With `ramp_en` low, a value written through `tgt_we`/`tgt_wdata` appears on `dac_code` on the clock edge that captures the write.
- R3: Raising `ramp_en` leaves `dac_code` unchanged until a different target is written. The counter already holds the target at that point.
- R4: With `ramp_en` high, the counter changes only on a tick, by exactly one count toward the target. It holds once it equals the target.
- R5: `rate_sel` picks the tick period in clock cycles: 00 gives CLK_HZ (1 Hz), 01 gives CLK_HZ/4 (4 Hz), 10 gives CLK_HZ/8 (8 Hz), 11 gives CLK_HZ/16 (16 Hz). The prescaler is held at zero while ramping is off. The first tick therefore arrives on the period-th clock edge with `ramp_en` high.
- R6: Writing a new target during a ramp turns the counting direction toward the new value from the next tick onward.
- R7: Clearing `ramp_en` in the middle of a ramp loads the target into the counter on the next clock edge.
- R8: While `fs_force` is high, `dac_code` is FFh in the same cycle, whatever the ramp state. The counter keeps ramping underneath. After release, `dac_code` shows the counter again.
- R9: While ramping, `dac_code` never changes by more than one count per clock cycle unless the override is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_we | input | 1 | Target register write strobe |
| tgt_wdata | input | 8 | Target speed value to write |
| ramp_en | input | 1 | Ramp enable (0 = target passes straight through) |
| rate_sel | input | 2 | Ramp tick rate select |
| fs_force | input | 1 | Full-scale override |
| dac_code | output | 8 | Code for the fan DAC |

## Verification
A write with the ramp off shows on `dac_code` one clock edge later. A ramp step appears on the edge where the prescaler reaches its period, with no further pipeline stage. The override and its release act combinationally in the same cycle. The bench drives inputs on falling edges. It updates a behavioural model of target, counter and prescaler on each rising edge and compares `dac_code` 3 ns later, after the edge has settled and before new inputs arrive. Directed checks for reversal, rate selection, override and mid-ramp disable are taken on falling edges at the cycle counts those latencies give.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    RATE_1HZ  = 2'b00,
    RATE_4HZ  = 2'b01,
    RATE_8HZ  = 2'b10,
    RATE_16HZ = 2'b11
  } rate_e;

  // Right shift applied to the clock frequency to get the tick period.
  function automatic int unsigned rate_shift(rate_e r);
    case (r)
      RATE_1HZ:  return 0;
      RATE_4HZ:  return 2;
      RATE_8HZ:  return 3;
      default:   return 4;
    endcase
  endfunction
endpackage

// File: rtl/fr_tick_gen.sv
module fr_tick_gen
  import fr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_000_000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  output logic  tick
);
  localparam int unsigned PW = (CLK_HZ > 2) ? $clog2(CLK_HZ) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic [PW-1:0] last;

  always_comb begin
    last = PW'((CLK_HZ >> rate_shift(rate)) - 1);
    // >= covers a switch to a faster rate while the count is above the new limit
    tick = run && (pre_q >= last);
    if (!run || tick) pre_d = '0;
    else              pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/fr_ramp_core.sv
module fr_ramp_core #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ramp_en,
  input  logic          tgt_we,
  input  logic [CW-1:0] tgt_wdata,
  output logic [CW-1:0] tgt_q,
  output logic [CW-1:0] cnt_q
);
  logic [CW-1:0] cnt_d;
  logic          cnt_ce;
  logic          go_up;
  logic          go_dn;

  always_comb begin
    go_up  = cnt_q < tgt_q;
    go_dn  = cnt_q > tgt_q;
    cnt_ce = !ramp_en || (tick && (go_up || go_dn));
    if (!ramp_en)   cnt_d = tgt_we ? tgt_wdata : tgt_q;
    else if (go_up) cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_we) tgt_q <= tgt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fan_ramp_gen.sv
module fan_ramp_gen
  import fr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_000_000,
  parameter int unsigned CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tgt_we,
  input  logic [CW-1:0] tgt_wdata,
  input  logic          ramp_en,
  input  logic [1:0]    rate_sel,
  input  logic          fs_force,
  output logic [CW-1:0] dac_code
);
  logic          rst_meta;
  logic          rst_sync_n;
  logic          tick;
  logic [CW-1:0] tgt_code;
  logic [CW-1:0] cnt_code;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fr_tick_gen #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (ramp_en),
    .rate  (rate_e'(rate_sel)),
    .tick  (tick)
  );

  fr_ramp_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .ramp_en   (ramp_en),
    .tgt_we    (tgt_we),
    .tgt_wdata (tgt_wdata),
    .tgt_q     (tgt_code),
    .cnt_q     (cnt_code)
  );

  always_comb dac_code = fs_force ? {CW{1'b1}} : cnt_code;
endmodule

// File: rtl/fan_ramp_gen_chk.sv
module fan_ramp_gen_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ramp_en,
  input logic          tgt_we,
  input logic [CW-1:0] tgt_wdata,
  input logic          fs_force,
  input logic          tick,
  input logic [CW-1:0] tgt_code,
  input logic [CW-1:0] cnt_code,
  input logic [CW-1:0] dac_code
);
  // R2: pass-through write lands on the counter at the capturing edge
  a_r2_follow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_en && tgt_we) |=> (cnt_code == $past(tgt_wdata)));

  // R4: no movement between ticks
  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !tick) |=> $stable(cnt_code));

  // R4: counter stops at the target
  a_r4_stop_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && (cnt_code == tgt_code)) |=> $stable(cnt_code));

  // R5: prescaler idle while ramping is off
  a_r5_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |-> !tick);

  // R6: a tick below the target counts up
  a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && tick && (cnt_code < tgt_code)) |=> (cnt_code == CW'($past(cnt_code) + 1'b1)));

  // R6: a tick above the target counts down
  a_r6_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && tick && (cnt_code > tgt_code)) |=> (cnt_code == CW'($past(cnt_code) - 1'b1)));

  // R8: override gives full scale
  a_r8_force_full: assert property (@(posedge clk) disable iff (!rst_n)
    fs_force |-> (dac_code == {CW{1'b1}}));

  // R9: at most one count of change per cycle while ramping, override off
  a_r9_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !fs_force) |=> (fs_force ||
      (CW'(dac_code - $past(dac_code)) == CW'(0)) ||
      (CW'(dac_code - $past(dac_code)) == CW'(1)) ||
      (CW'(dac_code - $past(dac_code)) == {CW{1'b1}})));
endmodule

bind fan_ramp_gen fan_ramp_gen_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ramp_en   (ramp_en),
  .tgt_we    (tgt_we),
  .tgt_wdata (tgt_wdata),
  .fs_force  (fs_force),
  .tick      (tick),
  .tgt_code  (tgt_code),
  .cnt_code  (cnt_code),
  .dac_code  (dac_code)
);

// File: tb/fan_ramp_gen_bench.sv
`timescale 1ns/1ps
module fan_ramp_gen_bench;
  localparam int unsigned HZ = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tgt_we;
  logic [7:0] tgt_wdata;
  logic       ramp_en;
  logic [1:0] rate_sel;
  logic       fs_force;
  logic [7:0] dac_code;

  int n_cmp = 0;
  int n_bad = 0;
  string req = "R1";

  // behavioural reference state
  int m_tgt = 0;
  int m_cnt = 0;
  int m_pre = 0;

  fan_ramp_gen #(.CLK_HZ(HZ), .CW(8)) u_fan_ramp_gen (
    .clk(clk), .rst_n(rst_n), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .ramp_en(ramp_en), .rate_sel(rate_sel), .fs_force(fs_force), .dac_code(dac_code)
  );

  always #5 clk = ~clk;

  task automatic check(input string r, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: dac_code actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // reference model and per-cycle comparison
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_tgt = 0; m_cnt = 0; m_pre = 0;
    end else begin
      int period;
      bit tk;
      period = (rate_sel == 2'd0) ? HZ : (rate_sel == 2'd1) ? HZ / 4 :
               (rate_sel == 2'd2) ? HZ / 8 : HZ / 16;
      tk = ramp_en && (m_pre >= period - 1);
      if (!ramp_en)  m_pre = 0;
      else if (tk)   m_pre = 0;
      else           m_pre = m_pre + 1;
      if (!ramp_en)
        m_cnt = tgt_we ? int'(tgt_wdata) : m_tgt;
      else if (tk && m_cnt < m_tgt) m_cnt = m_cnt + 1;
      else if (tk && m_cnt > m_tgt) m_cnt = m_cnt - 1;
      if (tgt_we) m_tgt = int'(tgt_wdata);
    end
    #3;
    check(req, int'(dac_code), fs_force ? 255 : m_cnt);
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    tgt_we = 1'b1; tgt_wdata = v;
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v0;
    int v1;
    rst_n = 1'b0; tgt_we = 1'b0; tgt_wdata = '0; ramp_en = 1'b0;
    rate_sel = 2'd0; fs_force = 1'b0;
    idle(3);
    req = "R1";
    check("R1", int'(dac_code), 0);
    rst_n = 1'b1;
    idle(5);
    check("R1", int'(dac_code), 0);

    // R2: pass-through
    req = "R2";
    wr(8'h5A);
    check("R2", int'(dac_code), 8'h5A);
    wr(8'hC3);
    check("R2", int'(dac_code), 8'hC3);

    // R3: enable keeps the output
    req = "R3";
    ramp_en = 1'b1; rate_sel = 2'd3;
    idle(10);
    check("R3", int'(dac_code), 8'hC3);

    // R4: steps to target and holds
    req = "R4";
    wr(8'hC8);
    idle(14);
    check("R4", int'(dac_code), 8'hC8);
    idle(6);
    check("R4", int'(dac_code), 8'hC8);

    // R6: reversal mid-ramp
    req = "R6";
    wr(8'h10);
    idle(20);
    v0 = int'(dac_code);
    check("R6", int'(v0 < 8'hC8), 1);
    wr(8'hD0);
    idle(4);
    v1 = int'(dac_code);
    idle(10);
    check("R6", int'(dac_code), v1 + 5);

    // R5: tick periods per rate
    req = "R5";
    ramp_en = 1'b0;
    wr(8'h40);
    ramp_en = 1'b1; rate_sel = 2'd0;
    wr(8'h60);
    idle(HZ * 3 - 2);
    check("R5", int'(dac_code), 8'h43);
    rate_sel = 2'd1;
    v0 = int'(dac_code);
    idle(HZ);
    check("R5", int'(dac_code >= v0 + 3 && dac_code <= v0 + 5), 1);
    rate_sel = 2'd2;
    idle(HZ);
    check("R5", int'(dac_code > v0 + 4), 1);

    // R8: override mid-ramp, R9 covered per cycle
    req = "R8";
    rate_sel = 2'd3;
    wr(8'h00);
    idle(4);
    fs_force = 1'b1;
    #1 check("R8", int'(dac_code), 255);
    idle(8);
    check("R8", int'(dac_code), 255);
    fs_force = 1'b0;
    #1 check("R8", int'(dac_code), m_cnt);
    req = "R9";
    idle(10);

    // R7: disable mid-ramp loads target
    req = "R7";
    wr(8'hF0);
    idle(6);
    ramp_en = 1'b0;
    @(negedge clk);
    check("R7", int'(dac_code), 8'hF0);

    // R1: asynchronous reset mid-ramp
    req = "R1";
    ramp_en = 1'b1;
    wr(8'h20);
    idle(4);
    rst_n = 1'b0; ramp_en = 1'b0;
    #1 check("R1", int'(dac_code), 0);
    idle(3);
    rst_n = 1'b1;
    idle(5);
    check("R1", int'(dac_code), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule